// File: doc/BRIEF.md
# Round-Robin Next-Active-Port Selector

This block picks which of sixteen processing clusters gets the next vector. Each cluster raises one bit of a status vector while it can take work. The selector keeps a pointer to the port it granted last. It searches the status bits in circular order, starting at the port just after that pointer, and grants the first active one it meets. The status word is rotated by the pointer, so a plain lowest-bit finder does the search and its offset is mapped back to a real port number.

Two lanes of the same logic sit side by side. One lane picks the destination for input dispatch and the other picks the source for output collection. Each lane has its own status vector, take strobe and pointer, and neither lane affects the other. The consumer accepts a grant by pulsing take while the grant is valid. Only then does the pointer move to the granted port, so an unused grant is offered again.

Top module: `rr_port_picker`

## Requirements
- R1: While rst is high, and in the cycle after it falls with no clock edge yet, both lanes show valid = 0 and port = 0.
- R2: One clock edge after a status vector is presented, a lane's valid is 1 exactly when at least one of its sixteen status bits is set (bit k stands for port k).
- R3: When valid, the port is the first index with its status bit set, taken in circular order P+1, P+2, …, P (mod 16), where P is the lane's pointer.
- R4: A lane's pointer becomes the granted port only at an edge where take is 1 and valid is 1. Take while valid is 0 leaves the pointer unchanged. The new pointer already applies to the grant registered at that same edge.
- R5: If the only active status bit is the one at the pointer, that port is granted again.
- R6: With all status bits clear, valid is 0, port keeps its previous value and the pointer does not change.
- R7: The input and output lanes are independent. Status and take on one lane never change the other lane's outputs.
- R8: After reset the pointer is 15, so the first search starts at port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_status | input | 16 | Input lane: clusters able to take a vector |
| in_take | input | 1 | Input lane: consumer accepts the current grant |
| in_port | output | 4 | Input lane: granted port (registered) |
| in_valid | output | 1 | Input lane: grant is valid (registered) |
| out_status | input | 16 | Output lane: clusters holding a result |
| out_take | input | 1 | Output lane: consumer accepts the current grant |
| out_port | output | 4 | Output lane: granted port (registered) |
| out_valid | output | 1 | Output lane: grant is valid (registered) |

## Verification
Every result is due exactly one rising edge after its stimulus. The bench drives status and take on the falling edge, waits for the next rising edge, and samples 1 ns later. Its reference model advances the pointer and recomputes the circular search once per such edge, in the same order the requirements give: pointer update first, then the search. A take therefore shows its effect on the very next sample and never two edges later. This holds for both the directed corner cases and the random phase.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

  typedef enum logic {LANE_DISPATCH = 1'b0, LANE_COLLECT = 1'b1} lane_e;

  localparam int unsigned LANES = 2;

  // (base + off) mod n, valid for base < n and off <= n
  function automatic int unsigned wrap_sum(int unsigned base, int unsigned off,
                                           int unsigned n);
    int unsigned s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/rrp_rotate.sv
module rrp_rotate #(
  parameter int NPORT = 16,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic [NPORT-1:0] status,
  input  logic [PW-1:0]    base,
  output logic [NPORT-1:0] rot
);
  import rrp_pkg::*;

  // rot[i] is the status of the port that lies i+1 places after base
  for (genvar i = 0; i < NPORT; i++) begin : g_rot
    assign rot[i] = status[PW'(wrap_sum(int'(base), i + 1, NPORT))];
  end

endmodule

// File: rtl/rrp_first.sv
module rrp_first #(
  parameter int NPORT = 16,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic [NPORT-1:0] vec,
  output logic             hit,
  output logic [PW-1:0]    idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = PW'(i);
      end
    end
  end

endmodule

// File: rtl/rrp_lane.sv
module rrp_lane #(
  parameter int NPORT = 16,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] status,
  input  logic             take,
  output logic [PW-1:0]    port,
  output logic             valid
);
  import rrp_pkg::*;

  logic [PW-1:0]    ptr_q, ptr_nxt, port_q, off, grant;
  logic             valid_q, hit, take_ok;
  logic [NPORT-1:0] rot;

  assign take_ok = take && valid_q;
  assign ptr_nxt = take_ok ? port_q : ptr_q;

  rrp_rotate #(.NPORT(NPORT), .PW(PW)) u_rot (
    .status(status), .base(ptr_nxt), .rot(rot)
  );

  rrp_first #(.NPORT(NPORT), .PW(PW)) u_first (
    .vec(rot), .hit(hit), .idx(off)
  );

  assign grant = PW'(wrap_sum(int'(ptr_nxt), int'(off) + 1, NPORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= PW'(NPORT - 1);
      port_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_nxt;
      valid_q <= hit;
      if (hit) port_q <= grant;
    end
  end

  assign port  = port_q;
  assign valid = valid_q;

  // R2
  valid_any_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (valid_q == $past(|status)));

  // R3
  grant_active_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !$past(rst)) |-> ((($past(status) >> port_q) & 1) != 0));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(take && valid_q) |=> $stable(ptr_q));

  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (take && valid_q) |=> (ptr_q == $past(port_q)));

endmodule

// File: rtl/rr_port_picker.sv
module rr_port_picker #(
  parameter int NPORT = 16,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] in_status,
  input  logic             in_take,
  output logic [PW-1:0]    in_port,
  output logic             in_valid,
  input  logic [NPORT-1:0] out_status,
  input  logic             out_take,
  output logic [PW-1:0]    out_port,
  output logic             out_valid
);
  import rrp_pkg::*;

  logic [NPORT-1:0] st_a   [LANES];
  logic             take_a [LANES];
  logic [PW-1:0]    port_a [LANES];
  logic             val_a  [LANES];

  assign st_a[LANE_DISPATCH]   = in_status;
  assign take_a[LANE_DISPATCH] = in_take;
  assign st_a[LANE_COLLECT]    = out_status;
  assign take_a[LANE_COLLECT]  = out_take;

  // R7: one private lane per direction
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rrp_lane #(.NPORT(NPORT), .PW(PW)) u_lane (
      .clk(clk), .rst(rst), .status(st_a[g]), .take(take_a[g]),
      .port(port_a[g]), .valid(val_a[g])
    );
  end

  assign in_port   = port_a[LANE_DISPATCH];
  assign in_valid  = val_a[LANE_DISPATCH];
  assign out_port  = port_a[LANE_COLLECT];
  assign out_valid = val_a[LANE_COLLECT];

endmodule

// File: tb/sim_rr_port_picker.sv
module sim_rr_port_picker;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] in_status = '0, out_status = '0;
  logic in_take = 1'b0, out_take = 1'b0;
  logic [3:0] in_port, out_port;
  logic in_valid, out_valid;

  int n_cmp = 0, n_bad = 0;
  int m_ptr [2];
  int m_port[2];
  bit m_val [2];

  always #10 clk = ~clk;

  rr_port_picker u0 (
    .clk(clk), .rst(rst),
    .in_status(in_status), .in_take(in_take), .in_port(in_port), .in_valid(in_valid),
    .out_status(out_status), .out_take(out_take), .out_port(out_port), .out_valid(out_valid)
  );

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(int l, logic [NP-1:0] st, bit tk);
    if (tk && m_val[l]) m_ptr[l] = m_port[l];
    m_val[l] = 1'b0;
    for (int k = 1; k <= NP; k++) begin
      int idx;
      idx = (m_ptr[l] + k) % NP;
      if (st[idx]) begin
        m_val[l]  = 1'b1;
        m_port[l] = idx;
        break;
      end
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "in_valid",  int'(in_valid),  int'(m_val[0]));
    cmp(req, "in_port",   int'(in_port),   m_port[0]);
    cmp(req, "out_valid", int'(out_valid), int'(m_val[1]));
    cmp(req, "out_port",  int'(out_port),  m_port[1]);
  endtask

  task automatic step(logic [NP-1:0] si, bit ti, logic [NP-1:0] so, bit to, string req);
    @(negedge clk);
    in_status = si; in_take = ti; out_status = so; out_take = to;
    @(posedge clk);
    model_step(0, si, ti);
    model_step(1, so, to);
    #1;
    check_all(req);
  endtask

  function automatic logic [NP-1:0] rnd_status();
    int unsigned r;
    r = $urandom % 4;
    if (r == 0) return '0;
    if (r == 1) return NP'(1) << ($urandom % NP);
    return NP'($urandom & $urandom);
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int l = 0; l < 2; l++) begin
      m_ptr[l] = NP - 1; m_port[l] = 0; m_val[l] = 1'b0;
    end
    in_status = '1; out_status = '1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_all("R1");
    // R8: first search from port 0
    step('1, 0, '1, 0, "R8");
    // R4: take moves pointer to 0, next grant 1; R6 on output lane
    step('1, 1, '0, 0, "R4");
    // R6: empty after accepted grant -> pointer 1, port held
    step('0, 1, '0, 1, "R6");
    // R4: take while invalid is ignored
    step('0, 1, '0, 0, "R4");
    // R5: only the pointer's own port active
    step(16'h0002, 0, 16'h8000, 0, "R5");
    step(16'h0002, 1, 16'h8000, 1, "R5");
    step(16'h0002, 0, 16'h8000, 0, "R5");
    // R3: wrap-around past port 15
    step(16'h0005, 1, 16'h0001, 1, "R3");
    step(16'h0005, 1, 16'h4001, 1, "R3");
    step(16'h0005, 1, 16'h4001, 1, "R3");
    // R7: output lane churns while input lane is held still
    for (int c = 0; c < 40; c++)
      step(16'h0100, 0, rnd_status(), 1'($urandom % 2), "R7");
    // R2 / R3: random mix
    for (int c = 0; c < 3000; c++)
      step(rnd_status(), 1'($urandom % 2), rnd_status(), 1'($urandom % 2),
           (c % 2 == 0) ? "R2" : "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule